// File: doc/BRIEF.md
# DDR2 Active Power-Down Entry/Exit Sequencer

This block owns the clock-enable line of a DDR2-style memory controller and decides when the command bus may carry real commands. It watches the write commands the controller issues and notes whether each one carried auto-precharge. It will not drop the clock-enable until the write data has landed and the device has recovered. The required gap is the write latency, plus half the burst length, plus either the write-to-read turnaround (plain write) or the programmed write-recovery count (auto-precharge write). Write latency is taken as the programmed read latency minus one.

A power-down request may arrive at any time. If the write gap is still running, the request is remembered and carried out as soon as the gap ends. From that point the command slot is forced to NOP. A wake request raises the clock-enable again on the next edge and keeps forcing NOPs until an exit count has passed. A mode bit picks the fast or the slow exit count. All clock-enable changes come from a register, so they meet input setup against the clock edge.

The controller is a five-state machine:
- IDLE: clock-enable high, commands allowed.
- WAIT: a write gap is running, commands still allowed.
- DRAIN: a power-down request is pending while the gap runs out, NOPs forced.
- PD: in power-down, clock-enable low.
- EXIT: clock-enable high, NOPs forced until the exit count expires.

The transitions are:
- IDLE to WAIT on a write.
- IDLE or WAIT to DRAIN on a request that arrives while a gap is running.
- IDLE, WAIT or DRAIN to PD on a request once the gap count is zero.
- WAIT to IDLE when the gap expires with no request.
- PD to EXIT on wake.
- EXIT to IDLE when the exit count expires.

Top module: `cke_pdn_seq`

## Requirements
- R1: After synchronous reset, `cke` is 1, `cmd_ok` is 1 and `force_nop` is 0.
- R2: After a write with `wr_ap`=0 sampled at edge T, with a power-down request given, `cke` falls at edge T+D, where D = WL + BL/2 + tWTR. WL = `cfg_rl`-1 (0 when `cfg_rl` is 0) and BL = `cfg_bl` beats.
- R3: After a write with `wr_ap`=1, the gap uses `cfg_wr` in place of `cfg_twtr`: D = WL + BL/2 + WR.
- R4: A power-down request seen before the gap expires is kept pending, even if it is a single-cycle pulse. It is carried out when the count reaches zero. While it is pending, `force_nop`=1 and `cmd_ok`=0.
- R5: A write that arrives during the gap (with or without a pending request) restarts the gap from its own edge, using its own `wr_ap` flag.
- R6: While `cke` is 0, `force_nop` is 1 and `cmd_ok` is 0.
- R7: A wake request sampled in power-down raises `cke` at the next edge. With `cfg_slow_exit`=0, `cmd_ok` returns to 1 at the edge X=`cfg_xp_fast` edges after `cke` rises.
- R8: With `cfg_slow_exit`=1, the exit count is `cfg_xp_slow` instead of `cfg_xp_fast`.
- R9: A wake request outside power-down has no effect. This holds in IDLE, where `cke` and `cmd_ok` stay 1, and in EXIT, where the exit count is not restarted.
- R10: A power-down request in IDLE with no gap running drops `cke` at the next edge.
- R11: At every cycle, exactly one of `cmd_ok` and `force_nop` is 1.
- R12: The delay counter saturates at zero. A computed gap or exit count of 0 acts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_cmd | input | 1 | A write command is issued this cycle |
| wr_ap | input | 1 | The write carries auto-precharge |
| pd_req | input | 1 | Request to enter active power-down |
| wake_req | input | 1 | Request to leave power-down |
| cfg_rl | input | LAT_W | Programmed read latency in cycles |
| cfg_bl | input | BL_W | Burst length in beats |
| cfg_twtr | input | LAT_W | Write-to-read delay in cycles |
| cfg_wr | input | LAT_W | Programmed write-recovery in cycles |
| cfg_slow_exit | input | 1 | 1 selects the slow exit count |
| cfg_xp_fast | input | XP_W | Fast exit count in cycles |
| cfg_xp_slow | input | XP_W | Slow exit count in cycles |
| cke | output | 1 | Registered clock-enable to the device |
| cmd_ok | output | 1 | A valid command may be issued |
| force_nop | output | 1 | The command slot must carry NOP |

## Verification
The bench keeps the default 4-bit timing fields. These let WL be 2 with a 4-beat burst, tWTR 2 and WR 3, so the plain and auto-precharge gaps differ by exactly one cycle. They also allow an 8-beat burst with WR 6, for a twelve-cycle gap. Because the two gaps differ by one cycle, a swapped recovery term or an unrestarted counter shows up as a one-cycle shift in the `cke` fall. The fast and slow exit counts are 2 and 6. An all-zero setting (read latency 1, no burst, zero exit count) reaches the saturated-zero corner.

// File: rtl/cke_pdn_pkg.sv
package cke_pdn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_DRAIN = 3'd2,
        ST_PD    = 3'd3,
        ST_EXIT  = 3'd4
    } pdn_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cke_pdn_delay.sv
module cke_pdn_delay #(
    parameter int LAT_W = 4,
    parameter int BL_W  = 4,
    parameter int XP_W  = 4,
    parameter int CNT_W = 6
) (
    input  logic [LAT_W-1:0] rd_lat,
    input  logic [BL_W-1:0]  burst_len,
    input  logic [LAT_W-1:0] t_wtr,
    input  logic [LAT_W-1:0] t_wr,
    input  logic             use_wr,
    input  logic             slow_exit,
    input  logic [XP_W-1:0]  xp_fast,
    input  logic [XP_W-1:0]  xp_slow,
    output logic [CNT_W-1:0] entry_load,
    output logic [CNT_W-1:0] exit_load
);

    logic [LAT_W-1:0] wr_lat;
    logic [LAT_W-1:0] recovery;
    logic [BL_W-1:0]  half_burst;
    logic [CNT_W-1:0] entry_sum;
    logic [XP_W-1:0]  exit_sel;

    always_comb begin
        wr_lat     = (rd_lat == '0) ? '0 : rd_lat - LAT_W'(1);
        recovery   = use_wr ? t_wr : t_wtr;
        half_burst = burst_len >> 1;
        entry_sum  = CNT_W'(wr_lat) + CNT_W'(half_burst) + CNT_W'(recovery);
        exit_sel   = slow_exit ? xp_slow : xp_fast;
        // Counter is loaded with (delay - 1) so the final edge lands on the delay count.
        entry_load = (entry_sum == '0) ? '0 : entry_sum - CNT_W'(1);
        exit_load  = (exit_sel == '0) ? '0 : CNT_W'(exit_sel) - CNT_W'(1);
    end

endmodule

// File: rtl/cke_pdn_counter.sv
module cke_pdn_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_zero = (cnt_q == '0);

    // R12: an idle counter stays at zero and never wraps.
    a_r12_sat_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt_zero && !load) |=> cnt_zero);

    // R12: without a load the count only moves downward by one.
    a_r12_step_down: assert property (@(posedge clk) disable iff (rst)
        (!cnt_zero && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/cke_pdn_seq.sv
module cke_pdn_seq
    import cke_pdn_pkg::*;
#(
    parameter int LAT_W = 4,
    parameter int BL_W  = 4,
    parameter int XP_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmd,
    input  logic             wr_ap,
    input  logic             pd_req,
    input  logic             wake_req,
    input  logic [LAT_W-1:0] cfg_rl,
    input  logic [BL_W-1:0]  cfg_bl,
    input  logic [LAT_W-1:0] cfg_twtr,
    input  logic [LAT_W-1:0] cfg_wr,
    input  logic             cfg_slow_exit,
    input  logic [XP_W-1:0]  cfg_xp_fast,
    input  logic [XP_W-1:0]  cfg_xp_slow,
    output logic             cke,
    output logic             cmd_ok,
    output logic             force_nop
);

    localparam int unsigned MAX_ENTRY = (2**LAT_W - 2) + ((2**BL_W - 1) / 2) + (2**LAT_W - 1);
    localparam int unsigned MAX_EXIT  = 2**XP_W - 1;
    localparam int unsigned MAX_ANY   = max_u(MAX_ENTRY, MAX_EXIT);
    localparam int          CNT_W     = $clog2(MAX_ANY + 1);

    pdn_state_e       state_q;
    pdn_state_e       state_d;
    logic [CNT_W-1:0] entry_load;
    logic [CNT_W-1:0] exit_load;
    logic             cnt_zero;
    logic             ld_entry;
    logic             ld_exit;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cke_q;

    cke_pdn_delay #(
        .LAT_W (LAT_W),
        .BL_W  (BL_W),
        .XP_W  (XP_W),
        .CNT_W (CNT_W)
    ) u_delay (
        .rd_lat     (cfg_rl),
        .burst_len  (cfg_bl),
        .t_wtr      (cfg_twtr),
        .t_wr       (cfg_wr),
        .use_wr     (wr_ap),
        .slow_exit  (cfg_slow_exit),
        .xp_fast    (cfg_xp_fast),
        .xp_slow    (cfg_xp_slow),
        .entry_load (entry_load),
        .exit_load  (exit_load)
    );

    always_comb begin
        ld_entry = wr_cmd && ((state_q == ST_IDLE) || (state_q == ST_WAIT) || (state_q == ST_DRAIN));
        ld_exit  = wake_req && (state_q == ST_PD);
        cnt_load = ld_entry || ld_exit;
        cnt_val  = ld_exit ? exit_load : entry_load;
    end

    cke_pdn_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .cnt_zero (cnt_zero)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_cmd) begin
                    state_d = pd_req ? ST_DRAIN : ST_WAIT;
                end else if (pd_req) begin
                    state_d = ST_PD;
                end
            end
            ST_WAIT: begin
                if (wr_cmd) begin
                    state_d = pd_req ? ST_DRAIN : ST_WAIT;
                end else if (pd_req) begin
                    state_d = cnt_zero ? ST_PD : ST_DRAIN;
                end else if (cnt_zero) begin
                    state_d = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (!wr_cmd && cnt_zero) begin
                    state_d = ST_PD;
                end
            end
            ST_PD: begin
                if (wake_req) begin
                    state_d = ST_EXIT;
                end
            end
            ST_EXIT: begin
                if (cnt_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: clock-enable changes only on the edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b1;
        end else begin
            cke_q <= (state_d != ST_PD);
        end
    end

    always_comb begin
        cke       = cke_q;
        cmd_ok    = (state_q == ST_IDLE) || (state_q == ST_WAIT);
        force_nop = !cmd_ok;
    end

    // R2: clock-enable may only drop once the gap counter has run out.
    a_r2_drop_after_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> $past(cnt_zero));

    // R7: clock-enable only rises in answer to a wake request.
    a_r7_rise_on_wake: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(wake_req));

    // R6: no command may pass while clock-enable is low.
    a_r6_nop_when_low: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (force_nop && !cmd_ok));

    // R11: the two command flags are always complementary.
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({cmd_ok, force_nop}) == 1);

    // R9: a wake while idle leaves the bus usable.
    a_r9_wake_idle_ignored: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && wake_req && !pd_req && !wr_cmd) |=> (cke && cmd_ok));

endmodule

// File: tb/cke_pdn_seq_tb.sv
`timescale 1ns/1ps
module cke_pdn_seq_tb;

    localparam int LAT_W = 4;
    localparam int BL_W  = 4;
    localparam int XP_W  = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_cmd, wr_ap, pd_req, wake_req;
    logic [LAT_W-1:0] cfg_rl, cfg_twtr, cfg_wr;
    logic [BL_W-1:0]  cfg_bl;
    logic             cfg_slow_exit;
    logic [XP_W-1:0]  cfg_xp_fast, cfg_xp_slow;
    logic             cke, cmd_ok, force_nop;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    cke_pdn_seq #(.LAT_W(LAT_W), .BL_W(BL_W), .XP_W(XP_W)) u_dut (
        .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_ap(wr_ap), .pd_req(pd_req),
        .wake_req(wake_req), .cfg_rl(cfg_rl), .cfg_bl(cfg_bl), .cfg_twtr(cfg_twtr),
        .cfg_wr(cfg_wr), .cfg_slow_exit(cfg_slow_exit), .cfg_xp_fast(cfg_xp_fast),
        .cfg_xp_slow(cfg_xp_slow), .cke(cke), .cmd_ok(cmd_ok), .force_nop(force_nop)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int entry_gap(input bit ap);
        int wl = (cfg_rl == 0) ? 0 : int'(cfg_rl) - 1;
        int d  = wl + int'(cfg_bl) / 2 + (ap ? int'(cfg_wr) : int'(cfg_twtr));
        return (d < 1) ? 1 : d;
    endfunction

    function automatic int exit_gap();
        int x = cfg_slow_exit ? int'(cfg_xp_slow) : int'(cfg_xp_fast);
        return (x < 1) ? 1 : x;
    endfunction

    // sel 0: count negedges with cke high; sel 1: with cmd_ok low
    task automatic count_while(input bit sel, output int n);
        n = 0;
        while (((sel == 0) ? cke : !cmd_ok) && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_exit(input string req, input bit hold_wake);
        int n, m;
        wake_req = 1;
        @(negedge clk);
        chk({req, " R7 cke raised"}, cke, 1);
        n = 0;
        if (hold_wake) begin
            if (!cmd_ok) n = 1;
            @(negedge clk);
        end
        wake_req = 0;
        count_while(1, m);
        chk({req, " exit count"}, n + m, exit_gap());
        chk({req, " R11 cmd_ok after exit"}, cmd_ok, 1);
    endtask

    task automatic do_entry(input string req, input bit ap, input bit pulse);
        int n, m;
        wr_cmd = 1; wr_ap = ap;
        @(negedge clk);
        wr_cmd = 0; wr_ap = 0; pd_req = 1;
        n = 0;
        if (pulse) begin
            if (cke) n = 1;
            @(negedge clk);
            pd_req = 0;
        end
        count_while(0, m);
        pd_req = 0;
        chk({req, " entry gap"}, n + m, entry_gap(ap));
    endtask

    task automatic t_reset();
        chk("R1 cke", cke, 1);
        chk("R1 cmd_ok", cmd_ok, 1);
        chk("R1 force_nop", force_nop, 0);
    endtask

    task automatic t_idle_entry();
        pd_req = 1;
        @(negedge clk);
        pd_req = 0;
        chk("R10 cke low next edge", cke, 0);
        chk("R6 force_nop in pd", force_nop, 1);
        chk("R6 cmd_ok in pd", cmd_ok, 0);
        repeat (3) @(negedge clk);
        chk("R6 cke stays low", cke, 0);
        do_exit("R7 fast", 0);
    endtask

    task automatic t_plain();
        do_entry("R2 R4 plain pulse", 0, 1);
        do_exit("R7 after plain", 0);
    endtask

    task automatic t_ap();
        do_entry("R3 ap bl4", 1, 0);
        do_exit("R7 after ap", 0);
        cfg_bl = 8; cfg_wr = 6;
        do_entry("R3 ap bl8 wr6", 1, 0);
        do_exit("R7 after long ap", 0);
        do_entry("R2 plain bl8", 0, 0);
        do_exit("R7 after plain bl8", 0);
        cfg_bl = 4; cfg_wr = 3;
    endtask

    task automatic t_restart();
        int m;
        wr_cmd = 1; wr_ap = 0;
        @(negedge clk);
        wr_cmd = 0; pd_req = 1;
        @(negedge clk);
        chk("R4 force_nop while pending", force_nop, 1);
        chk("R4 cmd_ok while pending", cmd_ok, 0);
        wr_cmd = 1; wr_ap = 1;
        @(negedge clk);
        wr_cmd = 0; wr_ap = 0;
        count_while(0, m);
        pd_req = 0;
        chk("R5 restart uses new ap write", m, entry_gap(1));
        do_exit("R7 after restart", 0);
    endtask

    task automatic t_slow();
        cfg_slow_exit = 1;
        pd_req = 1;
        @(negedge clk);
        pd_req = 0;
        do_exit("R8 slow", 0);
        cfg_slow_exit = 0;
    endtask

    task automatic t_wake_ignored();
        wake_req = 1;
        @(negedge clk);
        wake_req = 0;
        chk("R9 idle wake cke", cke, 1);
        chk("R9 idle wake cmd_ok", cmd_ok, 1);
        pd_req = 1;
        @(negedge clk);
        pd_req = 0;
        cfg_slow_exit = 1;
        do_exit("R9 wake held in exit", 1);
        cfg_slow_exit = 0;
    endtask

    task automatic t_zero();
        cfg_rl = 1; cfg_bl = 0; cfg_twtr = 0; cfg_xp_fast = 0;
        do_entry("R12 zero gap", 0, 0);
        do_exit("R12 zero exit", 0);
        cfg_rl = 3; cfg_bl = 4; cfg_twtr = 2; cfg_xp_fast = 2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; wr_cmd = 0; wr_ap = 0; pd_req = 0; wake_req = 0;
        cfg_rl = 3; cfg_bl = 4; cfg_twtr = 2; cfg_wr = 3;
        cfg_slow_exit = 0; cfg_xp_fast = 2; cfg_xp_slow = 6;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_idle_entry();
        t_plain();
        t_ap();
        t_restart();
        t_slow();
        t_wake_ignored();
        t_zero();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule